// File: doc/BRIEF.md
# Dual-Clock Cross-Triggered Trace Recorder

This block records two full-duplex byte streams that arrive on unrelated clocks. Each direction has its own recorder, running on its own interface clock. Every accepted sample is a 10-bit word: an 8-bit data byte, an enable bit and an error bit. The recorder writes the word into a circular RAM together with a timestamp. All timestamps come from one free-running counter in a reference clock domain. That count is carried into each capture domain in Gray code, so records from both directions can later be merged into one time-ordered listing.

The transmit-side recorder is the trigger master. It compares each incoming word with a programmable pattern under a per-bit mask. On the first match it marks the trigger location and sends a trigger event into the receive clock domain through a toggle synchronizer. The receive-side recorder never triggers on its own; it is slaved to this event. After its trigger, each recorder stores a programmable number of further samples, then raises done and stops accepting samples. Both buffers are then unloaded through plain addressed read ports, one per clock domain, each with one cycle of read latency.

Each sample input is a valid/ready stream. Ready is high from reset until the recorder finishes. After that, ready is low and offered samples are dropped: the data source is never stalled, because a trace recorder must not disturb the traffic it observes. A cycle with valid low stores nothing.

Top module: `trace_xtrig`

## Requirements
- R1: After reset both recorders show triggered low, done low and input ready high.
- R2: Each sample accepted (valid and ready high at a rising clock edge) is written at the next consecutive buffer address. A read returns {timestamp, word} at the following rising edge of that domain's clock, with the word in the low 10 bits.
- R3: The word layout is bit 9 error, bit 8 enable, bits 7:0 data. The transmit recorder triggers on the first accepted word with ((word XOR pattern) AND mask) equal to zero, where a mask bit of 1 means the bit is compared. The trigger pointer then holds that word's address and does not change until reset.
- R4: After the trigger, exactly post_len further accepted samples are stored. Done then goes high, ready goes low, and later offered samples are not stored.
- R5: The receive recorder triggers only on the transmit trigger event, after it crosses domains. Its trigger pointer is the address of the first receive sample accepted after the event arrives.
- R6: Each buffer is circular. Once more samples than the depth have been written, the newest entries overwrite the oldest, and the stored words stay in arrival order around the ring.
- R7: The timestamps stored in each buffer never decrease in write order.
- R8: A cycle with valid low writes nothing and advances no address.
- R9: With post_len equal to zero, the transmit recorder finishes on the trigger sample itself, and the receive recorder finishes as soon as the event arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock of the timestamp counter |
| rst_n | input | 1 | Active-low asynchronous reset, all domains |
| trig_pattern | input | 10 | Trigger compare value {err, en, data} |
| trig_mask | input | 10 | Per-bit compare enable, 1 = compare |
| post_len | input | POST_W | Samples stored after the trigger |
| tx_clk | input | 1 | Transmit capture clock |
| tx_in_valid | input | 1 | Transmit sample valid |
| tx_in_ready | output | 1 | Transmit recorder accepts samples |
| tx_in_word | input | 10 | Transmit sample {err, en, data} |
| tx_triggered | output | 1 | Transmit trigger has occurred |
| tx_done | output | 1 | Transmit capture finished |
| tx_trig_ptr | output | $clog2(DEPTH) | Address of the transmit trigger sample |
| tx_rd_addr | input | $clog2(DEPTH) | Transmit buffer read address |
| tx_rd_data | output | TS_W+10 | Transmit buffer entry {timestamp, word} |
| rx_clk | input | 1 | Receive capture clock, asynchronous |
| rx_in_valid | input | 1 | Receive sample valid |
| rx_in_ready | output | 1 | Receive recorder accepts samples |
| rx_in_word | input | 10 | Receive sample {err, en, data} |
| rx_triggered | output | 1 | Receive trigger event has arrived |
| rx_done | output | 1 | Receive capture finished |
| rx_trig_ptr | output | $clog2(DEPTH) | Address of the first post-trigger receive sample |
| rx_rd_addr | input | $clog2(DEPTH) | Receive buffer read address |
| rx_rd_data | output | TS_W+10 | Receive buffer entry {timestamp, word} |

## Verification
The bench uses DEPTH set to 16 and keeps the default 16-bit timestamp and post-length widths. The transmit clock runs at 5 ns, the receive clock at 7 ns and the reference clock at 3 ns. With a 16-entry ring, the receive side wraps its buffer several times before the transmit trigger arrives, so circular ordering and the cross-domain trigger pointer can both be checked across the wrap point. The faster reference clock makes the timestamps advance on every capture cycle. A second run with post_len zero and an all-zero mask exercises the immediate-finish corner in both domains.

// File: rtl/trace_pkg.sv
package trace_pkg;
  localparam int WORD_W = 10;

  typedef enum logic [1:0] {
    CAP_PRE  = 2'd0,
    CAP_POST = 2'd1,
    CAP_DONE = 2'd2
  } cap_state_e;
endpackage

// File: rtl/ts_counter.sv
module ts_counter #(
  parameter int TS_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [TS_W-1:0] gray
);
  logic [TS_W-1:0] bin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin  <= '0;
      gray <= '0;
    end else begin
      bin  <= bin + 1'b1;
      // registered Gray code so only one bit moves per reference cycle
      gray <= bin ^ (bin >> 1);
    end
  end
endmodule

// File: rtl/gray_sync.sv
module gray_sync #(
  parameter int TS_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TS_W-1:0] gray_in,
  output logic [TS_W-1:0] bin_out
);
  logic [TS_W-1:0] s1, s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= gray_in;
      s2 <= s1;
    end
  end

  always_comb begin
    bin_out[TS_W-1] = s2[TS_W-1];
    for (int i = TS_W - 2; i >= 0; i--) begin
      bin_out[i] = bin_out[i+1] ^ s2[i];
    end
  end
endmodule

// File: rtl/pulse_sync.sv
module pulse_sync (
  input  logic src_clk,
  input  logic dst_clk,
  input  logic rst_n,
  input  logic src_pulse,
  output logic dst_pulse
);
  logic tog;
  logic d1, d2, d3;

  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) tog <= 1'b0;
    else if (src_pulse) tog <= ~tog;
  end

  always_ff @(posedge dst_clk or negedge rst_n) begin
    if (!rst_n) begin
      d1 <= 1'b0;
      d2 <= 1'b0;
      d3 <= 1'b0;
    end else begin
      d1 <= tog;
      d2 <= d1;
      d3 <= d2;
    end
  end

  assign dst_pulse = d2 ^ d3;
endmodule

// File: rtl/trace_unit.sv
module trace_unit
  import trace_pkg::*;
#(
  parameter int DEPTH         = 64,
  parameter int TS_W          = 16,
  parameter int POST_W        = 16,
  parameter bit HIT_ON_SAMPLE = 1'b1,
  localparam int AW    = $clog2(DEPTH),
  localparam int ENT_W = TS_W + WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  input  logic              hit_in,
  input  logic [POST_W-1:0] post_len,
  input  logic [TS_W-1:0]   ts,
  output logic              triggered,
  output logic              done,
  output logic [AW-1:0]     trig_ptr,
  input  logic [AW-1:0]     rd_addr,
  output logic [ENT_W-1:0]  rd_data
);
  cap_state_e        state;
  logic [AW-1:0]     wptr;
  logic [AW-1:0]     mark;
  logic [POST_W-1:0] remain;
  logic              accept;
  logic              fire;
  logic [ENT_W-1:0]  mem [DEPTH];

  assign in_ready  = (state != CAP_DONE);
  assign triggered = (state != CAP_PRE);
  assign done      = (state == CAP_DONE);
  assign accept    = in_valid && in_ready;

  generate
    if (HIT_ON_SAMPLE) begin : g_master
      // trigger belongs to the sample that matched
      assign fire = (state == CAP_PRE) && hit_in && accept;
      assign mark = wptr;
    end else begin : g_slave
      // trigger points to the first slot after this cycle's write
      assign fire = (state == CAP_PRE) && hit_in;
      assign mark = wptr + {{(AW-1){1'b0}}, accept};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= CAP_PRE;
      wptr     <= '0;
      remain   <= '0;
      trig_ptr <= '0;
    end else begin
      if (accept) wptr <= wptr + 1'b1;
      unique case (state)
        CAP_PRE: begin
          if (fire) begin
            trig_ptr <= mark;
            remain   <= post_len;
            state    <= (post_len == '0) ? CAP_DONE : CAP_POST;
          end
        end
        CAP_POST: begin
          if (accept) begin
            remain <= remain - 1'b1;
            if (remain == {{(POST_W-1){1'b0}}, 1'b1}) state <= CAP_DONE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (accept) mem[wptr] <= {ts, in_word};
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/trace_xtrig.sv
module trace_xtrig
  import trace_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int TS_W   = 16,
  parameter int POST_W = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int ENT_W = TS_W + WORD_W
) (
  input  logic              ref_clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] trig_pattern,
  input  logic [WORD_W-1:0] trig_mask,
  input  logic [POST_W-1:0] post_len,
  input  logic              tx_clk,
  input  logic              tx_in_valid,
  output logic              tx_in_ready,
  input  logic [WORD_W-1:0] tx_in_word,
  output logic              tx_triggered,
  output logic              tx_done,
  output logic [AW-1:0]     tx_trig_ptr,
  input  logic [AW-1:0]     tx_rd_addr,
  output logic [ENT_W-1:0]  tx_rd_data,
  input  logic              rx_clk,
  input  logic              rx_in_valid,
  output logic              rx_in_ready,
  input  logic [WORD_W-1:0] rx_in_word,
  output logic              rx_triggered,
  output logic              rx_done,
  output logic [AW-1:0]     rx_trig_ptr,
  input  logic [AW-1:0]     rx_rd_addr,
  output logic [ENT_W-1:0]  rx_rd_data
);
  logic [TS_W-1:0] ts_gray;
  logic [TS_W-1:0] tx_ts, rx_ts;
  logic            tx_match, tx_evt, rx_evt;

  ts_counter #(.TS_W(TS_W)) u_ts (
    .clk(ref_clk), .rst_n(rst_n), .gray(ts_gray)
  );

  gray_sync #(.TS_W(TS_W)) u_ts_tx (
    .clk(tx_clk), .rst_n(rst_n), .gray_in(ts_gray), .bin_out(tx_ts)
  );

  gray_sync #(.TS_W(TS_W)) u_ts_rx (
    .clk(rx_clk), .rst_n(rst_n), .gray_in(ts_gray), .bin_out(rx_ts)
  );

  assign tx_match = ((tx_in_word ^ trig_pattern) & trig_mask) == '0;
  assign tx_evt   = tx_in_valid && tx_in_ready && tx_match && !tx_triggered;

  pulse_sync u_xtrig (
    .src_clk(tx_clk), .dst_clk(rx_clk), .rst_n(rst_n),
    .src_pulse(tx_evt), .dst_pulse(rx_evt)
  );

  trace_unit #(
    .DEPTH(DEPTH), .TS_W(TS_W), .POST_W(POST_W), .HIT_ON_SAMPLE(1'b1)
  ) u_tx (
    .clk(tx_clk), .rst_n(rst_n),
    .in_valid(tx_in_valid), .in_ready(tx_in_ready), .in_word(tx_in_word),
    .hit_in(tx_match), .post_len(post_len), .ts(tx_ts),
    .triggered(tx_triggered), .done(tx_done), .trig_ptr(tx_trig_ptr),
    .rd_addr(tx_rd_addr), .rd_data(tx_rd_data)
  );

  trace_unit #(
    .DEPTH(DEPTH), .TS_W(TS_W), .POST_W(POST_W), .HIT_ON_SAMPLE(1'b0)
  ) u_rx (
    .clk(rx_clk), .rst_n(rst_n),
    .in_valid(rx_in_valid), .in_ready(rx_in_ready), .in_word(rx_in_word),
    .hit_in(rx_evt), .post_len(post_len), .ts(rx_ts),
    .triggered(rx_triggered), .done(rx_done), .trig_ptr(rx_trig_ptr),
    .rd_addr(rx_rd_addr), .rd_data(rx_rd_data)
  );
endmodule

// File: rtl/trace_xtrig_chk.sv
module trace_xtrig_chk #(
  parameter int AW = 6
) (
  input logic          tx_clk,
  input logic          rx_clk,
  input logic          rst_n,
  input logic          tx_in_ready,
  input logic          tx_triggered,
  input logic          tx_done,
  input logic [AW-1:0] tx_trig_ptr,
  input logic          rx_in_ready,
  input logic          rx_triggered,
  input logic          rx_done,
  input logic [AW-1:0] rx_trig_ptr
);
  p_tx_done_blocks_r4: assert property (@(posedge tx_clk) disable iff (!rst_n)
    tx_done |-> !tx_in_ready);
  p_tx_done_sticky_r4: assert property (@(posedge tx_clk) disable iff (!rst_n)
    tx_done |=> tx_done);
  p_tx_done_after_trig_r4: assert property (@(posedge tx_clk) disable iff (!rst_n)
    tx_done |-> tx_triggered);
  p_tx_trig_sticky_r3: assert property (@(posedge tx_clk) disable iff (!rst_n)
    tx_triggered |=> tx_triggered);
  p_tx_ptr_frozen_r3: assert property (@(posedge tx_clk) disable iff (!rst_n)
    tx_triggered |=> $stable(tx_trig_ptr));
  p_rx_slaved_r5: assert property (@(posedge rx_clk) disable iff (!rst_n)
    rx_triggered |-> tx_triggered);
  p_rx_ptr_frozen_r5: assert property (@(posedge rx_clk) disable iff (!rst_n)
    rx_triggered |=> $stable(rx_trig_ptr));
  p_rx_done_blocks_r4: assert property (@(posedge rx_clk) disable iff (!rst_n)
    rx_done |-> (!rx_in_ready && rx_triggered));
endmodule

bind trace_xtrig trace_xtrig_chk #(.AW(AW)) u_chk (
  .tx_clk(tx_clk), .rx_clk(rx_clk), .rst_n(rst_n),
  .tx_in_ready(tx_in_ready), .tx_triggered(tx_triggered), .tx_done(tx_done),
  .tx_trig_ptr(tx_trig_ptr),
  .rx_in_ready(rx_in_ready), .rx_triggered(rx_triggered), .rx_done(rx_done),
  .rx_trig_ptr(rx_trig_ptr)
);

// File: tb/trace_xtrig_test.sv
module trace_xtrig_test;
  localparam int DEPTH = 16;
  localparam int TS_W  = 16;
  localparam int PW    = 16;
  localparam int AW    = $clog2(DEPTH);
  localparam int EW    = TS_W + 10;
  localparam int NVEC  = 12;
  // each entry: {valid, err, en, data}
  localparam logic [10:0] VEC [NVEC] = '{
    11'b1_0_1_00010000, 11'b0_0_1_11111111, 11'b1_0_1_10100100,
    11'b1_0_0_10100101, 11'b1_1_0_10100101, 11'b1_1_1_10100101,
    11'b1_0_1_00110000, 11'b1_0_1_00110001, 11'b1_0_1_00110010,
    11'b1_0_1_00110011, 11'b1_0_1_00110100, 11'b1_0_1_00110101
  };

  logic ref_clk = 0, tx_clk = 0, rx_clk = 0, rst_n = 0;
  logic [9:0] trig_pattern = 10'b0_1_10100101, trig_mask = 10'h1FF;
  logic [PW-1:0] post_len = 4;
  logic tx_in_valid = 0, tx_in_ready, tx_triggered, tx_done;
  logic [9:0] tx_in_word = '0;
  logic [AW-1:0] tx_trig_ptr, tx_rd_addr = '0;
  logic [EW-1:0] tx_rd_data;
  logic rx_in_valid = 0, rx_in_ready, rx_triggered, rx_done;
  logic [9:0] rx_in_word = '0;
  logic [AW-1:0] rx_trig_ptr, rx_rd_addr = '0;
  logic [EW-1:0] rx_rd_data;
  logic [7:0] rcnt = 0;
  int n_chk = 0, n_bad = 0, tx_cyc = 0;

  always #2.5 tx_clk = ~tx_clk;
  always #3.5 rx_clk = ~rx_clk;
  always #1.5 ref_clk = ~ref_clk;

  trace_xtrig #(.DEPTH(DEPTH), .TS_W(TS_W), .POST_W(PW)) uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd_tx(input int a, output logic [EW-1:0] d);
    @(negedge tx_clk) tx_rd_addr = AW'(a);
    @(posedge tx_clk); @(negedge tx_clk) d = tx_rd_data;
  endtask

  task automatic rd_rx(input int a, output logic [EW-1:0] d);
    @(negedge rx_clk) rx_rd_addr = AW'(a);
    @(posedge rx_clk); @(negedge rx_clk) d = rx_rd_data;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (6) @(negedge tx_clk);
    rst_n = 1;
  endtask

  // receive traffic: a byte counter, one sample per rx cycle
  initial begin
    forever begin
      @(negedge rx_clk);
      rx_in_valid = rst_n;
      rx_in_word  = {2'b01, rcnt};
      rcnt++;
    end
  end

  initial begin
    forever begin
      @(posedge tx_clk);
      tx_cyc++;
      if (tx_cyc > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=<150000", tx_cyc);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    end
  end

  initial begin
    logic [9:0] exp_w [DEPTH];
    logic [EW-1:0] d, prev;
    int cnt, tptr, rem, base;
    bit trig_m, done_m;

    do_reset();
    @(negedge tx_clk);
    chk("R1 tx_ready", 32'(tx_in_ready), 1);
    chk("R1 tx_trig", 32'(tx_triggered), 0);
    chk("R1 tx_done", 32'(tx_done), 0);
    chk("R1 rx_ready", 32'(rx_in_ready), 1);
    chk("R1 rx_done", 32'(rx_done), 0);

    // let the receive ring wrap before any trigger
    repeat (40) @(negedge tx_clk);
    chk("R5 rx no self trigger", 32'(rx_triggered), 0);

    cnt = 0; tptr = 0; rem = 0; trig_m = 0; done_m = 0;
    for (int i = 0; i < NVEC; i++) begin
      @(negedge tx_clk);
      chk("R4 tx_ready model", 32'(tx_in_ready), 32'(!done_m));
      tx_in_valid = VEC[i][10];
      tx_in_word  = VEC[i][9:0];
      if (VEC[i][10] && !done_m) begin
        exp_w[cnt] = VEC[i][9:0];
        if (trig_m) begin
          rem--;
          if (rem == 0) done_m = 1;
        end else if (((VEC[i][9:0] ^ trig_pattern) & trig_mask) == 0) begin
          trig_m = 1; tptr = cnt; rem = 4;
        end
        cnt++;
      end
    end
    @(negedge tx_clk) tx_in_valid = 0;

    chk("R3 tx triggered", 32'(tx_triggered), 1);
    chk("R3 tx trig ptr", 32'(tx_trig_ptr), 32'(tptr));
    chk("R3 tx trig ptr value", 32'(tptr), 4);
    chk("R4 tx done", 32'(tx_done), 1);
    chk("R8 stored count", 32'(cnt), 9);
    for (int a = 0; a < cnt; a++) begin
      rd_tx(a, d);
      chk("R2 tx word", 32'(d[9:0]), 32'(exp_w[a]));
      if (a > 0) chk("R7 tx ts order", 32'(d[EW-1:10] >= prev[EW-1:10]), 1);
      if (a == cnt - 1) chk("R7 tx ts advanced", 32'(d[EW-1:10] > 0), 1);
      prev = d;
    end
    rd_tx(cnt, d);
    chk("R4 dropped not stored", 32'(d[9:0] !== VEC[10][9:0]), 1);

    // receive side: wait for slaved finish
    repeat (30) @(negedge rx_clk);
    chk("R5 rx triggered", 32'(rx_triggered), 1);
    chk("R4 rx done", 32'(rx_done), 1);
    chk("R4 rx ready low", 32'(rx_in_ready), 0);
    base = (int'(rx_trig_ptr) + 4) % DEPTH;
    rd_rx(base, prev);
    for (int k = 1; k < DEPTH; k++) begin
      rd_rx((base + k) % DEPTH, d);
      chk("R6 rx ring order", 32'(d[7:0]), 32'(8'(prev[7:0] + 8'd1)));
      chk("R7 rx ts order", 32'(d[EW-1:10] >= prev[EW-1:10]), 1);
      prev = d;
    end

    // corner: match-all mask, no post samples
    trig_mask = '0; post_len = 0;
    do_reset();
    @(negedge tx_clk);
    chk("R1 tx_ready rerun", 32'(tx_in_ready), 1);
    tx_in_valid = 1; tx_in_word = 10'h3C3;
    @(negedge tx_clk) tx_in_valid = 0;
    chk("R9 tx done on trigger", 32'(tx_done), 1);
    chk("R9 tx trig ptr", 32'(tx_trig_ptr), 0);
    chk("R9 tx ready low", 32'(tx_in_ready), 0);
    rd_tx(0, d);
    chk("R2 tx trigger word", 32'(d[9:0]), 32'h3C3);
    repeat (10) @(negedge rx_clk);
    chk("R9 rx done at event", 32'(rx_done), 1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule